// File: doc/BRIEF.md
# Dithered Interpolating Pulse-Density Modulator

This block turns a stream of unsigned sample codes into a one-bit pulse-density stream. Each sample is spread over a fixed cycle of N output steps (N a power of two). A first-order accumulate-and-overflow loop emits a one whenever the running sum crosses full scale. Ones and zeros are therefore interleaved across the cycle rather than grouped, which pushes the modulation energy to high frequencies so that a simple analog filter can smooth it. A step enable sets the output rate. A new sample is taken through a valid/ready handshake at each cycle boundary.

Two optional modes change how a cycle is built. With interpolation on, the per-step increment ramps linearly at fixed point from the previous sample to the new one across the cycle. With dither on, the accumulator is seeded at each cycle boundary from an internal 16-bit pseudo-random sequence. This moves the pulse positions from cycle to cycle without changing how many pulses occur, which removes the tone at the sample rate. Both mode inputs are sampled only at the cycle boundary.

Top module: `pdm_modulator`

## Requirements
- R1: A synchronous active-high reset clears the step counter, the accumulator, the held sample, the ramp state and the output. After reset `pdm_out` and `in_ready` are 0.
- R2: A cycle is exactly N enabled steps, with N = 2^LOG2N. The counter and `pdm_out` change only on clock edges where `step_en` is 1, and otherwise hold their values.
- R3: `in_ready` is 1 only during an enabled step whose counter value is N-1, which is the last step of a cycle. A sample is transferred when `in_valid` and `in_ready` are both 1, and it governs the cycle that follows.
- R4: Without interpolation, the number of ones in a cycle equals the sample code taken for it, for any code from 0 to N inclusive. Code 0 gives no ones and code N gives a one on every step.
- R5: With dither off, the accumulator starts every cycle at 0. Recording the first step of a cycle as bit 0, code 1 gives a single one on the final step (pattern 0x8000 for N=16), and code N/2 gives alternating 0,1 starting with 0 (pattern 0xAAAA for N=16).
- R6: With dither on, the accumulator is loaded at the boundary with seed·N, where the seed is the low LOG2N bits of a 16-bit LFSR. The LFSR resets to 0xACE1 and advances once per cycle boundary, after its value is used, by shifting left and inserting the XOR of bits 15, 13, 12 and 10. The pulse count per cycle is unchanged, and the pulse position of a constant small code varies between cycles.
- R7: If no sample is transferred at a boundary, the previously held sample is reused for the next cycle with zero slope.
- R8: With interpolation on and a new sample b replacing held value a, step k (1..N) of the next cycle adds a·N + k·(b−a) to an accumulator scaled by N². The cycle then holds floor((seed·N + a·N² + (b−a)·N(N+1)/2) / N²) ones.
- R9: `interp_en` and `dither_en` take effect only through their values at the boundary step. A change that is undone before the boundary has no effect on the next cycle.
- R10: The per-step increment always stays within 0 to N² inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Output step enable; one modulator step per enabled clock |
| interp_en | input | 1 | Linear interpolation mode, sampled at the cycle boundary |
| dither_en | input | 1 | Random accumulator seeding, sampled at the cycle boundary |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample accepted on this edge if valid |
| in_data | input | LOG2N+1 | Unsigned sample code, 0 to N inclusive |
| pdm_out | output | 1 | Registered pulse-density output |

## Verification
The bench builds the block with LOG2N = 4, so one cycle is sixteen steps. The output of a whole cycle can then be captured as a 16-bit word and compared against exact patterns such as the lone final pulse and the alternating half-scale word. The small N makes the interpolation sums small enough to check the floor of a fractional pulse count (for example 5.625 down to 5), and lets the LFSR seed reach every position in a few cycles. A per-step behavioural model then follows every edge, including stretches where the step enable toggles and a reset arriving mid-cycle.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  localparam logic [15:0] LFSR_INIT = 16'hACE1;

  // 16-bit maximal-length Fibonacci step, taps 16,14,13,11
  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/pdm_cycle_ctr.sv
module pdm_cycle_ctr #(
  parameter int LOG2N = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  output logic [LOG2N-1:0] cnt,
  output logic             wrap
);
  localparam logic [LOG2N-1:0] CNT_LAST = '1;

  assign wrap = step_en && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (step_en) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pdm_dither_src.sv
module pdm_dither_src
  import pdm_pkg::*;
#(
  parameter int LOG2N = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [LOG2N-1:0] seed
);
  logic [15:0] state;

  always_ff @(posedge clk) begin
    if (rst) state <= LFSR_INIT;
    else if (advance) state <= lfsr_step(state);
  end

  generate
    if (LOG2N <= 16) begin : g_slice
      assign seed = state[LOG2N-1:0];
    end else begin : g_pad
      assign seed = {{(LOG2N-16){1'b0}}, state};
    end
  endgenerate
endmodule

// File: rtl/pdm_sample_path.sv
module pdm_sample_path #(
  parameter int LOG2N = 12,
  localparam int SW = LOG2N + 1,
  localparam int DW = LOG2N + 2,
  localparam int FW = 2 * LOG2N + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step_en,
  input  logic                 wrap,
  input  logic                 interp_en,
  input  logic                 in_valid,
  input  logic [SW-1:0]        in_data,
  output logic [FW-1:0]        dfix_q,
  output logic signed [DW-1:0] delta_q,
  output logic [FW-1:0]        dfix_step
);
  logic [SW-1:0] held_q;
  logic          take;

  function automatic logic [FW-1:0] scale_up(input logic [SW-1:0] s);
    return {s, {LOG2N{1'b0}}};
  endfunction

  function automatic logic signed [DW-1:0] slope(input logic [SW-1:0] nxt,
                                                 input logic [SW-1:0] cur);
    return $signed({1'b0, nxt}) - $signed({1'b0, cur});
  endfunction

  function automatic logic [FW-1:0] ramp(input logic [FW-1:0] d,
                                         input logic signed [DW-1:0] dl);
    logic signed [FW:0] t;
    t = $signed({1'b0, d}) + $signed({{(FW+1-DW){dl[DW-1]}}, dl});
    return t[FW-1:0];
  endfunction

  assign take      = wrap && in_valid;
  assign dfix_step = ramp(dfix_q, delta_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q  <= '0;
      delta_q <= '0;
      dfix_q  <= '0;
    end else if (wrap) begin
      if (take) begin
        held_q <= in_data;
        if (interp_en) begin
          delta_q <= slope(in_data, held_q);
          dfix_q  <= scale_up(held_q);
        end else begin
          delta_q <= '0;
          dfix_q  <= scale_up(in_data);
        end
      end else begin
        delta_q <= '0;
        dfix_q  <= scale_up(held_q);
      end
    end else if (step_en) begin
      dfix_q <= dfix_step;
    end
  end
endmodule

// File: rtl/pdm_accum.sv
module pdm_accum #(
  parameter int LOG2N = 12,
  localparam int FW = 2 * LOG2N + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             wrap,
  input  logic             dither_en,
  input  logic [LOG2N-1:0] seed,
  input  logic [FW-1:0]    incr,
  output logic [FW-1:0]    acc_q,
  output logic             pulse,
  output logic             pdm_out
);
  logic [FW-1:0] sum;

  function automatic logic [FW-1:0] seed_load(input logic on,
                                              input logic [LOG2N-1:0] s);
    return on ? {1'b0, s, {LOG2N{1'b0}}} : '0;
  endfunction

  assign sum   = acc_q + incr;
  assign pulse = sum[FW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      pdm_out <= 1'b0;
    end else if (step_en) begin
      pdm_out <= pulse;
      if (wrap) acc_q <= seed_load(dither_en, seed);
      else      acc_q <= {1'b0, sum[FW-2:0]};
    end
  end
endmodule

// File: rtl/pdm_modulator.sv
module pdm_modulator #(
  parameter int LOG2N = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step_en,
  input  logic           interp_en,
  input  logic           dither_en,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [LOG2N:0] in_data,
  output logic           pdm_out
);
  localparam int DW = LOG2N + 2;
  localparam int FW = 2 * LOG2N + 1;

  logic [LOG2N-1:0]     cyc_cnt;
  logic                 wrap;
  logic [LOG2N-1:0]     seed;
  logic [FW-1:0]        dfix_q;
  logic signed [DW-1:0] delta_q;
  logic [FW-1:0]        dfix_step;
  logic [FW-1:0]        acc_q;
  logic                 pulse;

  assign in_ready = wrap;

  pdm_cycle_ctr #(.LOG2N(LOG2N)) u_ctr (
    .clk(clk), .rst(rst), .step_en(step_en), .cnt(cyc_cnt), .wrap(wrap)
  );

  pdm_dither_src #(.LOG2N(LOG2N)) u_dith (
    .clk(clk), .rst(rst), .advance(wrap), .seed(seed)
  );

  pdm_sample_path #(.LOG2N(LOG2N)) u_samp (
    .clk(clk), .rst(rst), .step_en(step_en), .wrap(wrap),
    .interp_en(interp_en), .in_valid(in_valid), .in_data(in_data),
    .dfix_q(dfix_q), .delta_q(delta_q), .dfix_step(dfix_step)
  );

  pdm_accum #(.LOG2N(LOG2N)) u_acc (
    .clk(clk), .rst(rst), .step_en(step_en), .wrap(wrap),
    .dither_en(dither_en), .seed(seed), .incr(dfix_step),
    .acc_q(acc_q), .pulse(pulse), .pdm_out(pdm_out)
  );
endmodule

// File: rtl/pdm_modulator_chk.sv
module pdm_modulator_chk #(
  parameter int LOG2N = 12,
  localparam int DW = LOG2N + 2,
  localparam int FW = 2 * LOG2N + 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 step_en,
  input logic                 dither_en,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 pdm_out,
  input logic [LOG2N-1:0]     cnt,
  input logic [FW-1:0]        acc_q,
  input logic [FW-1:0]        dfix_q,
  input logic signed [DW-1:0] delta_q
);
  localparam logic [FW-1:0] FULL_SQ = {1'b1, {(FW-1){1'b0}}};

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (pdm_out == 1'b0 && cnt == '0 && acc_q == '0));

  assert_step_advance_R2: assert property (@(posedge clk) disable iff (rst)
    (step_en && !in_ready) |=> (cnt == $past(cnt) + 1'b1));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> ($stable(pdm_out) && $stable(cnt)));

  assert_ready_enabled_R3: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> step_en);

  assert_ready_then_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> (cnt == '0));

  assert_seed_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !dither_en) |=> (acc_q == '0));

  assert_stall_flat_R7: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> (delta_q == '0));

  assert_incr_range_R10: assert property (@(posedge clk) disable iff (rst)
    dfix_q <= FULL_SQ);
endmodule

bind pdm_modulator pdm_modulator_chk #(.LOG2N(LOG2N)) u_chk (
  .clk(clk), .rst(rst), .step_en(step_en), .dither_en(dither_en),
  .in_valid(in_valid), .in_ready(in_ready), .pdm_out(pdm_out),
  .cnt(cyc_cnt), .acc_q(acc_q), .dfix_q(dfix_q), .delta_q(delta_q)
);

// File: tb/sim_pdm_modulator.sv
module sim_pdm_modulator;
  localparam int L  = 4;
  localparam int N  = 1 << L;
  localparam int SW = L + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_en = 1'b0, interp_en = 1'b0, dither_en = 1'b0, in_valid = 1'b0;
  logic [SW-1:0] in_data = '0;
  wire in_ready, pdm_out;

  pdm_modulator #(.LOG2N(L)) u0 (
    .clk(clk), .rst(rst), .step_en(step_en), .interp_en(interp_en),
    .dither_en(dither_en), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .pdm_out(pdm_out)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference, integer arithmetic scaled by N*N
  longint m_acc, m_dfix, m_delta, m_held;
  int m_cnt, m_lfsr;
  bit m_out;
  bit t_step, t_wrap;
  int t_pos;

  function automatic int lfsr_adv(int s);
    int fb;
    fb = ^(s & 32'h0000B400);
    return ((s << 1) | fb) & 32'h0000FFFF;
  endfunction

  function automatic int interp_count(int a, int b);
    return (a * N * N + (b - a) * N * (N + 1) / 2) / (N * N);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_acc = 0; m_dfix = 0; m_delta = 0; m_held = 0; m_cnt = 0;
      m_out = 0; m_lfsr = 32'hACE1; t_step = 0; t_wrap = 0; t_pos = 0;
    end else begin
      t_step = step_en; t_wrap = 0; t_pos = m_cnt;
      if (step_en) begin
        m_dfix = m_dfix + m_delta;
        m_acc  = m_acc + m_dfix;
        m_out  = (m_acc >= N * N);
        if (m_out) m_acc = m_acc - N * N;
        if (m_cnt == N - 1) begin
          t_wrap = 1;
          if (in_valid) begin
            if (interp_en) begin
              m_delta = longint'(in_data) - m_held;
              m_dfix  = m_held * N;
            end else begin
              m_delta = 0;
              m_dfix  = longint'(in_data) * N;
            end
            m_held = in_data;
          end else begin
            m_delta = 0;
            m_dfix  = m_held * N;
          end
          m_acc  = dither_en ? longint'(m_lfsr % N) * N : 0;
          m_lfsr = lfsr_adv(m_lfsr);
          m_cnt  = 0;
        end else begin
          m_cnt = m_cnt + 1;
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  logic [N-1:0] pat = '0;
  logic [N-1:0] cyc_pat [0:63];
  int cyc = 0;

  task automatic tick();
    bit exp_rdy;
    @(negedge clk);
    exp_rdy = !rst && step_en && (m_cnt == N - 1);
    chk(pdm_out === m_out, "R4 pdm_out vs model", pdm_out, m_out);
    chk(in_ready === exp_rdy, "R3 in_ready vs model", in_ready, exp_rdy);
    if (!rst && t_step) pat[t_pos] = pdm_out;
    if (!rst && t_wrap) begin
      if (cyc < 64) cyc_pat[cyc] = pat;
      cyc++;
      pat = '0;
    end
  endtask

  // one cycle ending in boundary step; glitch pulses interp_en early on
  task automatic do_cycle(bit v, int d, bit ip, bit di, bit toggle, bit glitch);
    int n = 0;
    dither_en = di;
    in_valid  = v;
    in_data   = SW'(d);
    do begin
      interp_en = (glitch && n < N / 2) ? 1'b1 : ip;
      step_en   = toggle ? ~step_en : 1'b1;
      n++;
      tick();
    end while (!t_wrap);
    in_valid = 0;
  endtask

  function automatic int ones(logic [N-1:0] p);
    return $countones(p);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    finish_run();
  end

  initial begin
    step_en = 1;
    repeat (3) tick();
    // R1: reset state
    chk(pdm_out === 1'b0, "R1 out in reset", pdm_out, 0);
    chk(in_ready === 1'b0, "R1 ready in reset", in_ready, 0);
    rst = 0;

    do_cycle(1, 0,  0, 0, 0, 0);   // w0  -> c1
    do_cycle(1, 1,  0, 0, 0, 0);   // w1  -> c2
    do_cycle(1, 8,  0, 0, 0, 0);   // w2  -> c3
    do_cycle(1, 16, 0, 0, 0, 0);   // w3  -> c4
    do_cycle(1, 5,  0, 0, 0, 0);   // w4  -> c5
    do_cycle(0, 0,  0, 0, 0, 0);   // w5  -> c6 stall
    do_cycle(1, 1,  0, 1, 0, 0);   // w6  -> c7 dither
    do_cycle(1, 1,  0, 1, 0, 0);   // w7  -> c8
    do_cycle(1, 1,  0, 1, 0, 0);   // w8  -> c9
    do_cycle(1, 1,  0, 1, 0, 0);   // w9  -> c10
    do_cycle(1, 4,  0, 0, 0, 1);   // w10 -> c11, interp glitch
    do_cycle(1, 12, 1, 0, 0, 0);   // w11 -> c12 ramp 4..12
    do_cycle(1, 12, 1, 0, 0, 0);   // w12 -> c13 flat
    do_cycle(1, 0,  1, 0, 0, 0);   // w13 -> c14 ramp 12..0
    do_cycle(0, 0,  1, 0, 0, 0);   // w14 -> c15 stall
    do_cycle(1, 16, 1, 0, 0, 0);   // w15 -> c16 ramp 0..16
    do_cycle(1, 16, 1, 1, 0, 0);   // w16 -> c17 interp + dither
    do_cycle(1, 3,  0, 0, 0, 0);   // w17 -> c18
    do_cycle(0, 0,  0, 0, 1, 0);   // w18, c18 with toggled step_en

    chk(cyc_pat[0] == '0, "R1 first cycle empty", cyc_pat[0], 0);
    chk(ones(cyc_pat[1]) == 0, "R4 code 0 count", ones(cyc_pat[1]), 0);
    chk(cyc_pat[2] == 16'h8000, "R5 code 1 pattern", cyc_pat[2], 16'h8000);
    chk(cyc_pat[3] == 16'hAAAA, "R5 half-scale pattern", cyc_pat[3], 16'hAAAA);
    chk(cyc_pat[4] == 16'hFFFF, "R4 full-scale pattern", cyc_pat[4], 16'hFFFF);
    chk(ones(cyc_pat[5]) == 5, "R4 code 5 count", ones(cyc_pat[5]), 5);
    chk(ones(cyc_pat[6]) == 5, "R7 stall reuse count", ones(cyc_pat[6]), 5);
    for (int i = 7; i <= 10; i++)
      chk(ones(cyc_pat[i]) == 1, "R6 dither count", ones(cyc_pat[i]), 1);
    chk(!(cyc_pat[7] == cyc_pat[8] && cyc_pat[8] == cyc_pat[9] &&
          cyc_pat[9] == cyc_pat[10]), "R6 dither positions vary",
        cyc_pat[7], -1);
    chk(ones(cyc_pat[11]) == 4, "R9 glitch ignored", ones(cyc_pat[11]), 4);
    chk(ones(cyc_pat[12]) == interp_count(4, 12), "R8 ramp up count",
        ones(cyc_pat[12]), interp_count(4, 12));
    chk(ones(cyc_pat[13]) == 12, "R8 flat count", ones(cyc_pat[13]), 12);
    chk(ones(cyc_pat[14]) == interp_count(12, 0), "R8 ramp down count",
        ones(cyc_pat[14]), interp_count(12, 0));
    chk(ones(cyc_pat[15]) == 0, "R7 interp stall count", ones(cyc_pat[15]), 0);
    chk(ones(cyc_pat[16]) == interp_count(0, 16), "R8 ramp full count",
        ones(cyc_pat[16]), interp_count(0, 16));
    chk(ones(cyc_pat[17]) == 16, "R6 dither keeps count", ones(cyc_pat[17]), 16);
    chk(ones(cyc_pat[18]) == 3, "R2 gated steps count", ones(cyc_pat[18]), 3);

    // R1: reset arriving mid-cycle
    step_en = 1;
    in_valid = 1; in_data = SW'(16);
    repeat (5) tick();
    rst = 1;
    tick();
    chk(pdm_out === 1'b0, "R1 out after mid reset", pdm_out, 0);
    chk(in_ready === 1'b0, "R1 ready after mid reset", in_ready, 0);
    rst = 0; in_valid = 0;
    repeat (3) tick();
    chk(pdm_out === 1'b0, "R1 out stays low after reset", pdm_out, 0);

    finish_run();
  end
endmodule